// File: doc/BRIEF.md
# Legacy Memory Route Decoder

This block sits in a host bridge and decides, for every memory access below 1 MiB, whether it is served by main DRAM or forwarded to the expansion bus. Software programs byte-wide configuration registers for this decision. One register holds a 2-bit attribute for the 64 KiB top segment. A run of registers holds packed nibble attributes for the twelve 16 KiB option-ROM segments between 0xC0000 and 0xEFFFF. A separate control byte governs the 128 KiB video window.

Each access is presented as a 20-bit address with a read/write flag. One clock later the block returns a one-hot target and a write-suppress flag. The write-suppress flag marks writes that land in a read-only DRAM segment and must be discarded. The video window reaches DRAM only when the processor is in system management mode with the window opened for that mode, or when a force-open bit is set. A configuration write in the same cycle as an access affects only later accesses.

Top module: `lowmem_route_decoder`

## Requirements
- R1: After reset, configuration offsets 0x59 to 0x5F read back 0x00 and offset 0x72 reads back 0x02. The response outputs are idle: rsp_valid 0, rsp_target 2'b00, rsp_wr_drop 0.
- R2: A write with cfg_we high stores the full byte at offsets 0x59 to 0x5F and 0x72, and cfg_rdata returns the stored byte for cfg_addr in the same cycle. Any other offset reads 0x00, and writes to it change nothing.
- R3: rsp_valid is high exactly in the cycle after a cycle with req_valid high. While it is high, rsp_target is one-hot, with bit 0 meaning DRAM and bit 1 meaning expansion bus. While it is low, rsp_target is 2'b00 and rsp_wr_drop is 0.
- R4: Addresses below 0xA0000 always go to DRAM with rsp_wr_drop 0.
- R5: Addresses 0xA0000 to 0xBFFFF go to DRAM when smm_active is high in the request cycle and bit 3 of offset 0x72 is set, or whenever bit 6 of offset 0x72 is set. Otherwise they go to the bus. rsp_wr_drop is 0 in this window.
- R6: Segment i = (address - 0xC0000) / 0x4000 (0 to 11) takes its attribute from offset 0x5A + i/2. It uses bits [1:0] when i is even and bits [5:4] when i is odd.
- R7: Addresses 0xF0000 to 0xFFFFF take their attribute from bits [5:4] of offset 0x59.
- R8: Attribute 3 routes to DRAM with rsp_wr_drop 0. Attribute 1 routes to DRAM with rsp_wr_drop equal to the write flag. Attributes 0 and 2 route to the bus with rsp_wr_drop 0.
- R9: A configuration write in the same cycle as a request does not affect that request's decode. It does affect the request in the next cycle.
- R10: Bits [3:2] and [7:6] of the attribute bytes, and bits [3:0] of offset 0x59, have no effect on routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset for read and write |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte at cfg_addr |
| smm_active | input | 1 | System management mode is active |
| req_valid | input | 1 | Access request present |
| req_addr | input | 20 | Access address |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Decode result present |
| rsp_target | output | 2 | One-hot target: bit 0 DRAM, bit 1 expansion bus |
| rsp_wr_drop | output | 1 | Write must not be stored |

## Verification
The bench attacks segment edges: 0x9FFFF against 0xA0000, 0xBFFFF against 0xC0000, and 0xEFFFF against 0xF0000. An off-by-one segment index there would read the neighbouring nibble or put the video window under attribute control. It separates the SMM-gated open bit from the force bit, and checks that reserved nibble bits stay inert. A decoder that masked the nibble wrongly would send 0xC-valued segments to DRAM. A configuration write issued alongside an access must not leak into that access. A decoder that used the incoming byte instead of the stored one would route one access early.

// File: rtl/lowmem_route_pkg.sv
package lowmem_route_pkg;

    typedef enum logic [1:0] {
        ATTR_BUS_A   = 2'd0,
        ATTR_DRAM_RO = 2'd1,
        ATTR_BUS_B   = 2'd2,
        ATTR_DRAM_RW = 2'd3
    } seg_attr_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_DRAM = 2'b01,
        TGT_BUS  = 2'b10
    } target_e;

    typedef struct packed {
        logic    valid;
        target_e target;
        logic    wr_drop;
    } route_resp_t;

endpackage

// File: rtl/lowmem_cfg_regs.sv
module lowmem_cfg_regs #(
    parameter int                  CFG_AW          = 8,
    parameter int                  DW              = 8,
    parameter int                  NUM_ROM_SEG     = 12,
    parameter logic [CFG_AW-1:0]   ATTR_BASE       = 8'h59,
    parameter logic [CFG_AW-1:0]   SMRAM_ADDR      = 8'h72,
    parameter logic [DW-1:0]       SMRAM_RESET     = 8'h02,
    parameter int                  SMRAM_OPEN_BIT  = 3,
    parameter int                  SMRAM_FORCE_BIT = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [DW-1:0]            cfg_wdata,
    output logic [DW-1:0]            cfg_rdata,
    output logic [NUM_ROM_SEG*2-1:0] rom_attr_flat,
    output logic [1:0]               top_attr,
    output logic                     smram_open,
    output logic                     smram_force
);

    localparam int NUM_ATTR = 1 + (NUM_ROM_SEG + 1) / 2;
    localparam int NIB      = DW / 2;
    localparam int TOP_LSB  = NIB;

    typedef struct packed {
        logic [NUM_ATTR-1:0][DW-1:0] attr;
        logic [DW-1:0]               smram;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic [NUM_ATTR-1:0] attr_hit;
    logic                smram_hit;

    for (genvar g = 0; g < NUM_ATTR; g++) begin : g_hit
        localparam logic [CFG_AW-1:0] OFFSET = ATTR_BASE + CFG_AW'(g);
        assign attr_hit[g] = (cfg_addr == OFFSET);
    end
    assign smram_hit = (cfg_addr == SMRAM_ADDR);

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_ATTR; k++) begin
            if (cfg_we && attr_hit[k]) begin
                st_d.attr[k] = cfg_wdata;
            end
        end
        if (cfg_we && smram_hit) begin
            st_d.smram = cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.attr  <= '0;
            st_q.smram <= SMRAM_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int k = 0; k < NUM_ATTR; k++) begin
            if (attr_hit[k]) begin
                cfg_rdata = st_q.attr[k];
            end
        end
        if (smram_hit) begin
            cfg_rdata = st_q.smram;
        end
    end

    for (genvar g = 0; g < NUM_ROM_SEG; g++) begin : g_rom
        localparam int BYTE_IDX = 1 + g / 2;
        localparam int BIT_LO   = (g % 2) * NIB;
        assign rom_attr_flat[g*2 +: 2] = st_q.attr[BYTE_IDX][BIT_LO +: 2];
    end

    assign top_attr    = st_q.attr[0][TOP_LSB +: 2];
    assign smram_open  = st_q.smram[SMRAM_OPEN_BIT];
    assign smram_force = st_q.smram[SMRAM_FORCE_BIT];

endmodule

// File: rtl/lowmem_seg_attr.sv
module lowmem_seg_attr
    import lowmem_route_pkg::*;
#(
    parameter int SEG_W        = 6,
    parameter int NUM_ROM_SEG  = 12,
    parameter int ROM_BASE_SEG = 48,
    parameter int TOP_BASE_SEG = 60
) (
    input  logic [SEG_W-1:0]         seg_idx,
    input  logic [NUM_ROM_SEG*2-1:0] rom_attr_flat,
    input  logic [1:0]               top_attr,
    output seg_attr_e                attr
);

    logic [SEG_W-1:0] rom_off;

    always_comb begin
        rom_off = seg_idx - SEG_W'(ROM_BASE_SEG);
        attr    = seg_attr_e'(top_attr);
        if (seg_idx < SEG_W'(TOP_BASE_SEG)) begin
            attr = ATTR_BUS_A;
            for (int k = 0; k < NUM_ROM_SEG; k++) begin
                if (rom_off == SEG_W'(k)) begin
                    attr = seg_attr_e'(rom_attr_flat[k*2 +: 2]);
                end
            end
        end
    end

endmodule

// File: rtl/lowmem_route_logic.sv
module lowmem_route_logic
    import lowmem_route_pkg::*;
#(
    parameter int                ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] VIDEO_BASE = 20'hA0000,
    parameter logic [ADDR_W-1:0] ROM_BASE   = 20'hC0000
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              smm_active,
    input  logic              smram_open,
    input  logic              smram_force,
    input  seg_attr_e         seg_attr,
    output target_e           target,
    output logic              wr_drop
);

    always_comb begin
        target  = TGT_BUS;
        wr_drop = 1'b0;
        if (req_addr < VIDEO_BASE) begin
            target = TGT_DRAM;
        end else if (req_addr < ROM_BASE) begin
            if ((smm_active && smram_open) || smram_force) begin
                target = TGT_DRAM;
            end
        end else begin
            case (seg_attr)
                ATTR_DRAM_RW: target = TGT_DRAM;
                ATTR_DRAM_RO: begin
                    target  = TGT_DRAM;
                    wr_drop = req_write;
                end
                default:      target = TGT_BUS;
            endcase
        end
    end

endmodule

// File: rtl/lowmem_route_decoder.sv
module lowmem_route_decoder
    import lowmem_route_pkg::*;
#(
    parameter int                  CFG_AW          = 8,
    parameter int                  DW              = 8,
    parameter int                  ADDR_W          = 20,
    parameter int                  SEG_SHIFT       = 14,
    parameter int                  NUM_ROM_SEG     = 12,
    parameter logic [CFG_AW-1:0]   ATTR_BASE       = 8'h59,
    parameter logic [CFG_AW-1:0]   SMRAM_ADDR      = 8'h72,
    parameter logic [DW-1:0]       SMRAM_RESET     = 8'h02,
    parameter int                  SMRAM_OPEN_BIT  = 3,
    parameter int                  SMRAM_FORCE_BIT = 6,
    parameter logic [ADDR_W-1:0]   VIDEO_BASE      = 20'hA0000,
    parameter logic [ADDR_W-1:0]   ROM_BASE        = 20'hC0000,
    parameter logic [ADDR_W-1:0]   TOP_BASE        = 20'hF0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              smm_active,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [1:0]        rsp_target,
    output logic              rsp_wr_drop
);

    localparam int SEG_W        = ADDR_W - SEG_SHIFT;
    localparam int ROM_BASE_SEG = int'(ROM_BASE >> SEG_SHIFT);
    localparam int TOP_BASE_SEG = int'(TOP_BASE >> SEG_SHIFT);

    logic [NUM_ROM_SEG*2-1:0] rom_attr_flat;
    logic [1:0]               top_attr;
    logic                     smram_open;
    logic                     smram_force;
    seg_attr_e                seg_attr;
    target_e                  route_target;
    logic                     route_drop;

    route_resp_t resp_d, resp_q;

    lowmem_cfg_regs #(
        .CFG_AW          (CFG_AW),
        .DW              (DW),
        .NUM_ROM_SEG     (NUM_ROM_SEG),
        .ATTR_BASE       (ATTR_BASE),
        .SMRAM_ADDR      (SMRAM_ADDR),
        .SMRAM_RESET     (SMRAM_RESET),
        .SMRAM_OPEN_BIT  (SMRAM_OPEN_BIT),
        .SMRAM_FORCE_BIT (SMRAM_FORCE_BIT)
    ) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .rom_attr_flat (rom_attr_flat),
        .top_attr      (top_attr),
        .smram_open    (smram_open),
        .smram_force   (smram_force)
    );

    lowmem_seg_attr #(
        .SEG_W        (SEG_W),
        .NUM_ROM_SEG  (NUM_ROM_SEG),
        .ROM_BASE_SEG (ROM_BASE_SEG),
        .TOP_BASE_SEG (TOP_BASE_SEG)
    ) u_seg (
        .seg_idx       (req_addr[ADDR_W-1:SEG_SHIFT]),
        .rom_attr_flat (rom_attr_flat),
        .top_attr      (top_attr),
        .attr          (seg_attr)
    );

    lowmem_route_logic #(
        .ADDR_W     (ADDR_W),
        .VIDEO_BASE (VIDEO_BASE),
        .ROM_BASE   (ROM_BASE)
    ) u_route (
        .req_addr    (req_addr),
        .req_write   (req_write),
        .smm_active  (smm_active),
        .smram_open  (smram_open),
        .smram_force (smram_force),
        .seg_attr    (seg_attr),
        .target      (route_target),
        .wr_drop     (route_drop)
    );

    always_comb begin
        resp_d = '0;
        if (req_valid) begin
            resp_d.valid   = 1'b1;
            resp_d.target  = route_target;
            resp_d.wr_drop = route_drop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rsp_valid   = resp_q.valid;
    assign rsp_target  = resp_q.target;
    assign rsp_wr_drop = resp_q.wr_drop;

endmodule

// File: rtl/lowmem_route_decoder_chk.sv
module lowmem_route_decoder_chk #(
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] LOW_LIMIT = 20'hA0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              rsp_valid,
    input logic [1:0]        rsp_target,
    input logic              rsp_wr_drop
);

    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r3_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r3_target_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_target) == 1));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_target == 2'b00 && !rsp_wr_drop));

    a_r4_low_to_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr < LOW_LIMIT) |=> (rsp_target == 2'b01 && !rsp_wr_drop));

    a_r8_read_never_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !rsp_wr_drop);

    a_r8_drop_only_dram: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_drop |-> (rsp_target == 2'b01));

endmodule

bind lowmem_route_decoder lowmem_route_decoder_chk u_chk (.*);

// File: tb/lowmem_route_decoder_test.sv
`timescale 1ns/1ps
module lowmem_route_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        smm_active;
    logic        req_valid;
    logic [19:0] req_addr;
    logic        req_write;
    logic        rsp_valid;
    logic [1:0]  rsp_target;
    logic        rsp_wr_drop;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [7:0] cfg_model [0:255];

    always #5 clk = ~clk;

    lowmem_route_decoder uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .smm_active (smm_active),
        .req_valid (req_valid), .req_addr (req_addr), .req_write (req_write),
        .rsp_valid (rsp_valid), .rsp_target (rsp_target), .rsp_wr_drop (rsp_wr_drop)
    );

    function automatic bit is_impl(logic [7:0] a);
        return (a >= 8'h59 && a <= 8'h5F) || a == 8'h72;
    endfunction

    // returns {target[1:0], drop}: DRAM = 2'b01, bus = 2'b10
    function automatic logic [2:0] exp_route(logic [19:0] a, logic w, logic smm);
        logic [1:0] at;
        int seg;
        logic [7:0] b;
        if (a < 20'hA0000) return 3'b010;
        if (a < 20'hC0000)
            return ((smm && cfg_model[8'h72][3]) || cfg_model[8'h72][6]) ? 3'b010 : 3'b100;
        if (a >= 20'hF0000) begin
            at = cfg_model[8'h59][5:4];
        end else begin
            seg = int'(a - 20'hC0000) / 16384;
            b   = cfg_model[8'h5A + seg / 2];
            at  = (seg % 2 == 1) ? b[5:4] : b[1:0];
        end
        case (at)
            2'd3:    return 3'b010;
            2'd1:    return {2'b01, w};
            default: return 3'b100;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic cycle(logic we, logic [7:0] ca, logic [7:0] cd, logic rv,
                         logic [19:0] a, logic w, logic smm, string req);
        logic [2:0] e;
        @(negedge clk);
        cfg_we = we; cfg_addr = ca; cfg_wdata = cd;
        req_valid = rv; req_addr = a; req_write = w; smm_active = smm;
        e = exp_route(a, w, smm);
        @(posedge clk);
        #1;
        if (rv) chk(req, {28'd0, rsp_valid, rsp_target, rsp_wr_drop}, {28'd0, 1'b1, e});
        else    chk(req, {28'd0, rsp_valid, rsp_target, rsp_wr_drop}, 32'd0);
        if (we && is_impl(ca)) cfg_model[ca] = cd;
    endtask

    task automatic wr(logic [7:0] ca, logic [7:0] cd);
        cycle(1'b1, ca, cd, 1'b0, 20'h0, 1'b0, 1'b0, "R3 idle during write");
    endtask

    task automatic rd(logic [7:0] ca, string req);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0; cfg_addr = ca;
        #1;
        chk(req, {24'd0, cfg_rdata}, {24'd0, is_impl(ca) ? cfg_model[ca] : 8'h00});
    endtask

    task automatic acc(logic [19:0] a, logic w, logic smm, string req);
        cycle(1'b0, 8'h00, 8'h00, 1'b1, a, w, smm, req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) cfg_model[i] = 8'h00;
        cfg_model[8'h72] = 8'h02;
        void'($urandom(32'd4411));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        smm_active = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 rsp idle", {29'd0, rsp_valid, rsp_target}, 32'd0);
        chk("R1 drop idle", {31'd0, rsp_wr_drop}, 32'd0);
        for (int k = 8'h59; k <= 8'h5F; k++) rd(8'(k), "R1 attr reset");
        rd(8'h72, "R1 smram reset");

        // R2 storage and unimplemented offsets
        wr(8'h5C, 8'hA5);  rd(8'h5C, "R2 readback");
        wr(8'h40, 8'hFF);  rd(8'h40, "R2 unimplemented reads zero");
        rd(8'h58, "R2 below range"); rd(8'h60, "R2 above range");

        // R4 low memory
        acc(20'h00000, 1'b0, 1'b0, "R4 low read");
        acc(20'h9FFFF, 1'b1, 1'b0, "R4 low top write");
        cycle(1'b0, 8'h00, 8'h00, 1'b0, 20'h12345, 1'b0, 1'b0, "R3 no request");

        // R5 video window
        acc(20'hA0000, 1'b0, 1'b0, "R5 reset bus");
        acc(20'hA0000, 1'b0, 1'b1, "R5 smm without open bit");
        wr(8'h72, 8'h08);
        acc(20'hB0000, 1'b1, 1'b0, "R5 open bit no smm");
        acc(20'hBFFFF, 1'b1, 1'b1, "R5 open bit with smm");
        wr(8'h72, 8'h40);
        acc(20'hA0000, 1'b0, 1'b0, "R5 force open");
        wr(8'h72, 8'h02);

        // R6 / R8 segment attributes
        wr(8'h5A, 8'h31);
        acc(20'hC3FFF, 1'b1, 1'b0, "R8 read-only write dropped");
        acc(20'hC0000, 1'b0, 1'b0, "R8 read-only read kept");
        acc(20'hC4000, 1'b1, 1'b0, "R6 odd segment rw");
        wr(8'h5F, 8'h23);
        acc(20'hE8000, 1'b1, 1'b0, "R6 segment 10");
        acc(20'hEFFFF, 1'b0, 1'b0, "R6 segment 11 bus");

        // R10 ignored bits
        wr(8'h5B, 8'hCC);
        acc(20'hC8000, 1'b0, 1'b0, "R10 reserved bits even");
        acc(20'hCC000, 1'b1, 1'b0, "R10 reserved bits odd");

        // R7 top segment
        wr(8'h59, 8'h10);
        acc(20'hF0000, 1'b0, 1'b0, "R7 top read-only read");
        acc(20'hFFFFF, 1'b1, 1'b0, "R7 top read-only write");
        wr(8'h59, 8'h0F);
        acc(20'hF8000, 1'b0, 1'b0, "R10 top low bits ignored");

        // R9 same-cycle config write
        wr(8'h5C, 8'h00);
        cycle(1'b1, 8'h5C, 8'h03, 1'b1, 20'hD0000, 1'b1, 1'b0, "R9 old value used");
        acc(20'hD0000, 1'b1, 1'b0, "R9 new value next");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic       we, rv, w, smm;
            logic [7:0] ca, cd;
            logic [19:0] a;
            int r;
            we = ($urandom % 4) == 0;
            r  = $urandom % 9;
            if (r < 7)       ca = 8'(8'h59 + r);
            else if (r == 7) ca = 8'h72;
            else             ca = 8'($urandom);
            cd  = 8'($urandom);
            rv  = ($urandom % 8) != 0;
            if ($urandom % 2 == 1) a = 20'hA0000 + 20'($urandom % 32'h60000);
            else                   a = 20'($urandom);
            w   = 1'($urandom & 1);
            smm = 1'($urandom & 1);
            cycle(we, ca, cd, rv, a, w, smm, "R5/R6/R7/R8/R9 random");
        end
        for (int k = 8'h59; k <= 8'h5F; k++) rd(8'(k), "R2 final readback");
        rd(8'h72, "R2 final smram");

        done = 1'b1;
        finish_run();
    end

endmodule